// File: doc/BRIEF.md
# I2C Target with Channel Setting Registers

This block is a byte-oriented I2C target that owns a small bank of per-channel output-setting registers. It oversamples SCL and SDA with the system clock and recognises START, repeated START and STOP. It accepts its own 7-bit address, in which two select inputs supply bits 2 and 1. It then takes a memory pointer and writes or reads data bytes with the usual acknowledge handshake. SDA is driven only as an open-drain enable: when the enable is 1 the line is pulled low.

A write transaction carries the target address with the R/W bit at 0, a pointer byte, and one or more data bytes. A read transaction normally follows a write of the pointer. After a repeated START with the R/W bit at 1, the target streams bytes from the pointer for as long as the controller acknowledges them. Any change on the select inputs is a hardware abort: the transaction in flight is dropped and SDA is released.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset every channel register reads 00h and the SDA enable is 0.
- R2: The target address is the 7-bit base 1010000b with select bit 1 in address bit 2 and select bit 0 in address bit 1. With both selects at 0 the write byte is A0h and the read byte is A1h. With the selects at 01b the write byte is A4h. A matching address byte is acknowledged by pulling SDA low during the ninth bit.
- R3: An address byte that does not match is not acknowledged. SDA is then never driven and no register changes until the next START.
- R4: In a write, the byte after the address loads the pointer and the next byte is stored at the pointer. Both bytes are acknowledged. Channel registers change only through such stores.
- R5: The pointer advances by one after every data byte written or read. Stores to addresses outside F8h to F8h+NCH-1 are acknowledged and discarded.
- R6: In a read, bytes are sent MSB first, starting at the pointer. Another byte follows each controller ACK (SDA 0). After a NACK (SDA 1) the target releases SDA.
- R7: Reading an address with no register returns 00h.
- R8: A channel register keeps bit 7 (sink/source) and bits 4:0 (magnitude) of a stored byte. Bits 6:5 always read 0.
- R9: A change on either select input releases SDA on the next clock. It also discards a data byte whose store would fall in the same cycle. The new address applies from the next START.
- R10: A STOP returns the target to idle with SDA released.
- R11: The SDA enable changes only after an SCL falling edge, or on START, STOP or abort. Driven data therefore stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sel_i | input | 2 | Address select inputs; bit 1 is address bit 2, bit 0 is address bit 1 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| chan_o | output | NCH*8 | Channel registers, channel 0 in the low byte |

## Verification
Two events can land in one clock cycle: a select-input abort and the SCL falling edge that ends the eighth bit of a data byte. That falling edge is where the store is committed and the acknowledge is raised. The bench changes the select inputs at the same instant it drops SCL after the last data bit. Both paths pass through synchronisers of equal depth, so the two events reach the engine together. The collision is judged correct if SDA stays released through the ninth bit, the target register keeps its old value, and a fresh START with the new address is acknowledged.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXACK,
      ST_TX,
      ST_TXACK
   } eng_state_t;

   typedef enum logic [1:0] {
      RX_ADDR,
      RX_PTR,
      RX_DATA
   } rx_kind_t;

   localparam int BYTE_W = 8;

   // place the select inputs on address bits 2:1
   function automatic logic [6:0] target_addr(input logic [6:0] base,
                                              input logic [1:0] sel);
      return base | {4'b0000, sel, 1'b0};
   endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] q_prev_o
);

   logic [STAGES-1:0][W-1:0] chain;
   logic [W-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
         prev <= RST_VAL;
      end else begin
         chain[0] <= d_i;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         prev <= chain[STAGES-1];
      end
   end

   assign q_o      = chain[STAGES-1];
   assign q_prev_o = prev;

endmodule

// File: rtl/i2c_rf_cond.sv
module i2c_rf_cond (
   input  logic scl_q,
   input  logic scl_p,
   input  logic sda_q,
   input  logic sda_p,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);

   // SDA moves while SCL stays high: bus condition
   assign start_o = scl_q & scl_p & sda_p & ~sda_q;
   assign stop_o  = scl_q & scl_p & ~sda_p & sda_q;
   assign rise_o  = scl_q & ~scl_p;
   assign fall_o  = ~scl_q & scl_p;

endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank #(
   parameter int         NCH       = 2,
   parameter logic [7:0] REG_BASE  = 8'hF8,
   parameter logic [7:0] CHAN_MASK = 8'h9F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [7:0]       rd_addr,
   output logic [7:0]       rd_data,
   output logic [NCH*8-1:0] chan_o
);

   logic [7:0] regs [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      localparam logic [7:0] MY_ADDR = 8'(REG_BASE + g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= 8'h00;
         else if (wr_en && (wr_addr == MY_ADDR))
            regs[g] <= wr_data & CHAN_MASK;
      end

      assign chan_o[g*8 +: 8] = regs[g];
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NCH; i++)
         if (rd_addr == 8'(REG_BASE + i)) rd_data = regs[i];
   end

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       scl_rise_i,
   input  logic       scl_fall_i,
   input  logic       sda_i,
   input  logic [1:0] sel_i,
   input  logic [7:0] rd_data_i,
   output logic       wr_en_o,
   output logic [7:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   output logic [7:0] rd_addr_o,
   output logic       sda_oe_o
);

   eng_state_t state;
   rx_kind_t   kind;
   logic [3:0] cnt;
   logic [7:0] shift;
   logic [7:0] txsh;
   logic [7:0] ptr;
   logic       rw;
   logic       mack;
   logic       oe;
   logic [6:0] my_addr;
   logic       byte_end;

   assign my_addr  = target_addr(BASE_ADDR, sel_i);
   assign byte_end = scl_fall_i && (cnt == 4'd8);

   assign wr_en_o   = (state == ST_RX) && (kind == RX_DATA) && byte_end &&
                      !abort_i && !start_i && !stop_i;
   assign wr_addr_o = ptr;
   assign wr_data_o = shift;
   assign rd_addr_o = ptr;
   assign sda_oe_o  = oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         kind  <= RX_ADDR;
         cnt   <= '0;
         shift <= '0;
         txsh  <= '0;
         ptr   <= '0;
         rw    <= 1'b0;
         mack  <= 1'b0;
         oe    <= 1'b0;
      end else if (abort_i) begin
         state <= ST_IDLE;
         cnt   <= '0;
         oe    <= 1'b0;
      end else if (start_i) begin
         state <= ST_RX;
         kind  <= RX_ADDR;
         cnt   <= '0;
         oe    <= 1'b0;
      end else if (stop_i) begin
         state <= ST_IDLE;
         oe    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_RX: begin
               if (scl_rise_i && (cnt < 4'd8)) begin
                  shift <= {shift[6:0], sda_i};
                  cnt   <= cnt + 4'd1;
               end else if (byte_end) begin
                  cnt <= '0;
                  unique case (kind)
                     RX_ADDR: begin
                        if (shift[7:1] == my_addr) begin
                           rw    <= shift[0];
                           oe    <= 1'b1;
                           state <= ST_RXACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     RX_PTR: begin
                        ptr   <= shift;
                        oe    <= 1'b1;
                        state <= ST_RXACK;
                     end
                     default: begin
                        ptr   <= ptr + 8'd1;
                        oe    <= 1'b1;
                        state <= ST_RXACK;
                     end
                  endcase
               end
            end
            ST_RXACK: begin
               if (scl_fall_i) begin
                  cnt <= '0;
                  if ((kind == RX_ADDR) && rw) begin
                     txsh  <= rd_data_i;
                     ptr   <= ptr + 8'd1;
                     oe    <= ~rd_data_i[7];
                     state <= ST_TX;
                  end else begin
                     oe    <= 1'b0;
                     kind  <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
                     state <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall_i) begin
                  if (cnt == 4'd7) begin
                     cnt   <= '0;
                     oe    <= 1'b0;
                     state <= ST_TXACK;
                  end else begin
                     txsh <= {txsh[6:0], 1'b0};
                     oe   <= ~txsh[6];
                     cnt  <= cnt + 4'd1;
                  end
               end
            end
            ST_TXACK: begin
               if (scl_rise_i) mack <= ~sda_i;
               if (scl_fall_i) begin
                  if (mack) begin
                     txsh  <= rd_data_i;
                     ptr   <= ptr + 8'd1;
                     oe    <= ~rd_data_i[7];
                     cnt   <= '0;
                     state <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
   parameter int         NCH         = 2,
   parameter logic [6:0] BASE_ADDR   = 7'h50,
   parameter logic [7:0] REG_BASE    = 8'hF8,
   parameter logic [7:0] CHAN_MASK   = 8'h9F,
   parameter int         SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [1:0]       sel_i,
   output logic             sda_oe_o,
   output logic [NCH*8-1:0] chan_o
);

   localparam int LAST_ADDR = int'(REG_BASE) + NCH - 1;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("NCH must lie in 1..8");
   end
   if (LAST_ADDR > 255) begin : g_bad_base
      $error("register window passes FFh");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BASE_ADDR[2:1] != 2'b00) begin : g_bad_addr
      $error("BASE_ADDR bits 2:1 belong to the select inputs");
   end

   logic [1:0] bus_q, bus_p;
   logic [1:0] sel_q, sel_p;
   logic       start_w, stop_w, rise_w, fall_w, abort_w;
   logic       wr_en_w;
   logic [7:0] wr_addr_w, wr_data_w, rd_addr_w, rd_data_w;

   // bit 1 = SCL, bit 0 = SDA; idle bus is high
   i2c_rf_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}),
      .q_o(bus_q), .q_prev_o(bus_p)
   );

   i2c_rf_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sel_i),
      .q_o(sel_q), .q_prev_o(sel_p)
   );

   assign abort_w = |(sel_q ^ sel_p);

   i2c_rf_cond u_cond (
      .scl_q(bus_q[1]), .scl_p(bus_p[1]), .sda_q(bus_q[0]), .sda_p(bus_p[0]),
      .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
   );

   i2c_rf_engine #(.BASE_ADDR(BASE_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .abort_i(abort_w), .start_i(start_w),
      .stop_i(stop_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
      .sda_i(bus_q[0]), .sel_i(sel_q), .rd_data_i(rd_data_w),
      .wr_en_o(wr_en_w), .wr_addr_o(wr_addr_w), .wr_data_o(wr_data_w),
      .rd_addr_o(rd_addr_w), .sda_oe_o(sda_oe_o)
   );

   i2c_rf_bank #(.NCH(NCH), .REG_BASE(REG_BASE), .CHAN_MASK(CHAN_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_addr(wr_addr_w),
      .wr_data(wr_data_w), .rd_addr(rd_addr_w), .rd_data(rd_data_w),
      .chan_o(chan_o)
   );

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
   parameter int         NCH       = 2,
   parameter logic [7:0] REG_BASE  = 8'hF8,
   parameter logic [7:0] CHAN_MASK = 8'h9F
) (
   input logic             clk,
   input logic             rst_n,
   input logic             abort,
   input logic             start,
   input logic             stop,
   input logic             scl_fall,
   input logic             sda_oe,
   input logic             wr_en,
   input logic [7:0]       wr_addr,
   input logic [7:0]       wr_data,
   input logic [NCH*8-1:0] chan
);

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !sda_oe);

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !sda_oe);

   // R11
   oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> ($past(scl_fall) || $past(abort) || $past(start) || $past(stop)));

   // R4
   chan_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chan) |-> $past(wr_en));

   for (genvar g = 0; g < NCH; g++) begin : g_land
      // R8
      store_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_addr == 8'(REG_BASE + g))) |=>
            (chan[g*8 +: 8] == ($past(wr_data) & CHAN_MASK)));
   end

endmodule

bind i2c_regfile_target i2c_rf_checker #(
   .NCH(NCH), .REG_BASE(REG_BASE), .CHAN_MASK(CHAN_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort_w), .start(start_w), .stop(stop_w),
   .scl_fall(fall_w), .sda_oe(sda_oe_o), .wr_en(wr_en_w), .wr_addr(wr_addr_w),
   .wr_data(wr_data_w), .chan(chan_o)
);

// File: tb/i2c_regfile_target_bench.sv
`timescale 1ns/1ps
module i2c_regfile_target_bench;

   localparam int NCH = 2;
   localparam time Q  = 200ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scl = 1'b1;
   logic             msda = 1'b1;
   logic [1:0]       sel = 2'b00;
   logic             sda_oe;
   logic [NCH*8-1:0] chan;
   logic             sda_bus;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   assign sda_bus = msda & ~sda_oe;

   always #5 clk = ~clk;

   i2c_regfile_target u_i2c_regfile_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sel_i(sel), .sda_oe_o(sda_oe), .chan_o(chan)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      msda = 1'b1; #Q;
      scl  = 1'b1; #Q;
      msda = 1'b0; #Q;
      scl  = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      msda = 1'b0; #Q;
      scl  = 1'b1; #Q;
      msda = 1'b1; #Q;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         msda = b[i]; #Q;
         scl = 1'b1;  #Q;
         scl = 1'b0;
      end
      msda = 1'b1; #Q;
      scl = 1'b1; #(Q/2);
      ack = ~sda_bus; #(Q/2);
      scl = 1'b0; #Q;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d, output logic steady);
      steady = 1'b1;
      msda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         #Q;
         scl = 1'b1; #(Q/4);
         d[i] = sda_bus; #(Q/2);
         if (sda_bus !== d[i]) steady = 1'b0;
         #(Q/4);
         scl = 1'b0;
      end
      msda = give_ack ? 1'b0 : 1'b1; #Q;
      scl = 1'b1; #Q;
      scl = 1'b0;
      msda = 1'b1; #Q;
   endtask

   task automatic t_reset();
      chk("R1 channels", 32'(chan), 32'h0);
      chk("R1 sda enable", 32'(sda_oe), 32'h0);
   endtask

   task automatic t_write_basic();
      logic a;
      bus_start();
      send_byte(8'hA0, a); chk("R2 ack A0h", 32'(a), 32'h1);
      send_byte(8'hF8, a); chk("R4 pointer ack", 32'(a), 32'h1);
      send_byte(8'h85, a); chk("R4 data ack", 32'(a), 32'h1);
      bus_stop();
      chk("R4 channel 0 stored", 32'(chan[7:0]), 32'h85);
      bus_start();
      send_byte(8'hA0, a);
      send_byte(8'hF9, a);
      send_byte(8'hFF, a);
      bus_stop();
      chk("R8 bits 6:5 cleared", 32'(chan[15:8]), 32'h9F);
      chk("R10 released after stop", 32'(sda_oe), 32'h0);
   endtask

   task automatic t_read();
      logic a, st;
      logic [7:0] d;
      bus_start();
      send_byte(8'hA0, a);
      send_byte(8'hF8, a);
      bus_start();
      send_byte(8'hA1, a); chk("R2 ack A1h", 32'(a), 32'h1);
      recv_byte(1'b1, d, st);
      chk("R6 first byte", 32'(d), 32'h85);
      chk("R11 stable while SCL high", 32'(st), 32'h1);
      recv_byte(1'b0, d, st);
      chk("R6 second byte", 32'(d), 32'h9F);
      chk("R6 released after nack", 32'(sda_bus), 32'h1);
      bus_stop();
      chk("R10 idle after stop", 32'(sda_oe), 32'h0);
   endtask

   task automatic t_autoinc();
      logic a, st;
      logic [7:0] d;
      bus_start();
      send_byte(8'hA0, a);
      send_byte(8'hF8, a);
      send_byte(8'h11, a);
      send_byte(8'h1F, a);
      send_byte(8'h33, a); chk("R5 unimplemented store acked", 32'(a), 32'h1);
      bus_stop();
      chk("R5 increment stores", 32'(chan), 32'h1F11);
      bus_start();
      send_byte(8'hA0, a);
      send_byte(8'hF9, a);
      bus_start();
      send_byte(8'hA1, a);
      recv_byte(1'b1, d, st); chk("R5 read at F9h", 32'(d), 32'h1F);
      recv_byte(1'b0, d, st); chk("R7 read past bank", 32'(d), 32'h00);
      bus_stop();
      chk("R5 discarded store left bank", 32'(chan), 32'h1F11);
   endtask

   task automatic t_mismatch();
      logic a;
      bus_start();
      send_byte(8'hA2, a); chk("R3 no ack on wrong address", 32'(a), 32'h0);
      send_byte(8'hF8, a); chk("R3 ignored byte", 32'(a), 32'h0);
      send_byte(8'h55, a); chk("R3 ignored data", 32'(a), 32'h0);
      bus_stop();
      chk("R3 bank untouched", 32'(chan), 32'h1F11);
   endtask

   task automatic t_sel();
      logic a;
      sel = 2'b01; #Q;
      bus_start();
      send_byte(8'hA0, a); chk("R2 old address refused", 32'(a), 32'h0);
      bus_stop();
      bus_start();
      send_byte(8'hA4, a); chk("R2 ack A4h", 32'(a), 32'h1);
      send_byte(8'hF8, a);
      send_byte(8'h66, a);
      bus_stop();
      chk("R2 store via new address", 32'(chan[7:0]), 32'h06);
   endtask

   task automatic t_abort_collide();
      logic a;
      logic [7:0] b;
      b = 8'h9A;
      bus_start();
      send_byte(8'hA4, a);
      send_byte(8'hF8, a);
      for (int i = 7; i >= 0; i--) begin
         msda = b[i]; #Q;
         scl = 1'b1; #Q;
         if (i == 0) sel = 2'b00;
         scl = 1'b0;
      end
      msda = 1'b1; #Q;
      chk("R9 sda released in ack slot", 32'(sda_oe), 32'h0);
      scl = 1'b1; #(Q/2);
      chk("R9 no ack", 32'(sda_bus), 32'h1);
      #(Q/2);
      scl = 1'b0; #Q;
      bus_stop();
      chk("R9 store discarded", 32'(chan[7:0]), 32'h06);
      bus_start();
      send_byte(8'hA0, a); chk("R9 new address acked", 32'(a), 32'h1);
      bus_stop();
   endtask

   initial begin
      #1;
      rst_n = 1'b0;
      #100;
      rst_n = 1'b1;
      #100;
      t_reset();
      t_write_basic();
      t_read();
      t_autoinc();
      t_mismatch();
      t_sel();
      t_abort_collide();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule